// File: doc/BRIEF.md
# Indirect Control-Register Window with Init-Block Fetch

This block is the host-facing register slave of a network controller. The host sees only two 16-bit locations. One is an index port that holds a 2-bit register selector. The other is a data port that reads or writes whichever of four internal control registers the index names. Every register access therefore takes two steps: first store the index, then touch the data port.

The four registers are a control/status register, the low 16 bits and the high 8 bits of a 24-bit word address, and a small bus configuration register. Setting the start bit in the control register launches an autonomous fetch of a 12-word initialization image from memory. The fetch uses a simple word-read master: request with address, then a grant that returns the word. The fetched words go into an internal image that the controller's other logic, and the testbench, can read through an index/word port. When the fetch completes, a sticky done flag is set, and the interrupt line follows it when enabled.

Top module: `indirect_csr_port`

## Requirements
- R1: After reset the index, all four registers, the done flag and the interrupt are zero, and `mem_req` is low.
- R2: A write with `host_port`=1 stores `host_wdata[1:0]` as the index. Reading with `host_port`=1 returns the index in bits 1:0, and bits 15:2 read as zero.
- R3: With `host_port`=0, reads and writes reach the register named by the index (0 control, 1 address low, 2 address high, 3 bus config). Register 1 stores all 16 bits.
- R4: Register 2 keeps only bits 7:0 and register 3 keeps only bits 2:0. All other bits of these registers read as zero.
- R5: Writing 1 to control bit 0 while idle starts a fetch. Control bit 0 reads 1 while the fetch runs and 0 afterwards. Starting a fetch clears the done flag.
- R6: A fetch makes exactly 12 word reads, at addresses {reg2[7:0],reg1}, +1, ... +11. `mem_req` stays high with `mem_addr` stable until `mem_gnt`, and the word on `mem_rdata` is taken in the grant cycle.
- R7: `img_word` returns fetched word `img_idx` (0..11), and 0 for larger indices. When register 3 bit 0 was set at start, each word is stored with its two bytes swapped.
- R8: Control bit 8 (done) is set after the 12th word arrives. Writing 1 to it clears it, and writing 0 leaves it set.
- R9: `irq` is high exactly when control bit 8 and control bit 6 (interrupt enable) are both set.
- R10: While a fetch runs, data-port writes to registers 1, 2 and 3 are ignored.
- R11: Fetch addresses increment modulo 2^24, so a fetch that starts near the top of the space wraps to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_port | input | 1 | 0 selects the data port, 1 selects the index port |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data for the selected port |
| mem_req | output | 1 | Memory word-read request |
| mem_addr | output | 24 | Memory word address |
| mem_gnt | input | 1 | Grant; `mem_rdata` is valid in the same cycle |
| mem_rdata | input | 16 | Memory read data |
| img_idx | input | 4 | Index into the fetched image |
| img_word | output | 16 | Selected image word |
| irq | output | 1 | Interrupt request |

## Verification
The hardest condition to reach is a host write that lands while a fetch is still in flight, together with a grant pattern that stalls the master at random. The bench's memory model withholds grants at random, which stretches each fetch over many cycles. The bench issues register writes straight after the start command, while the request is provably still pending. One directed fetch starts at the top of the 24-bit space to force the address to wrap.

// File: rtl/icp_pkg.sv
package icp_pkg;
    typedef enum logic [1:0] {
        REG_CTRL    = 2'd0,
        REG_ADDR_LO = 2'd1,
        REG_ADDR_HI = 2'd2,
        REG_BUSCFG  = 2'd3
    } reg_idx_e;

    localparam logic PORT_DATA = 1'b0;
    localparam logic PORT_IDX  = 1'b1;

    localparam int unsigned CTRL_START_BIT = 0;
    localparam int unsigned CTRL_IEN_BIT   = 6;
    localparam int unsigned CTRL_DONE_BIT  = 8;
    localparam int unsigned CFG_SWAP_BIT   = 0;
endpackage

// File: rtl/icp_regfile.sv
module icp_regfile
    import icp_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned MEM_AW = 24,
    parameter int unsigned CFG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              sel_port,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              fetch_busy,
    input  logic              fetch_done,
    output logic              start,
    output logic [MEM_AW-1:0] base_addr,
    output logic              cfg_swap,
    output logic              done_flag,
    output logic              irq
);
    localparam int unsigned HI_W = MEM_AW - DATA_W;

    typedef struct packed {
        reg_idx_e          idx;
        logic [DATA_W-1:0] lo;
        logic [HI_W-1:0]   hi;
        logic [CFG_W-1:0]  cfg;
        logic              ien;
        logic              done;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        start  = 1'b0;
        if (wr_en) begin
            if (sel_port == PORT_IDX) begin
                regs_d.idx = reg_idx_e'(wr_data[1:0]);
            end else begin
                case (regs_q.idx)
                    REG_CTRL: begin
                        regs_d.ien = wr_data[CTRL_IEN_BIT];
                        if (wr_data[CTRL_DONE_BIT]) regs_d.done = 1'b0;
                        if (wr_data[CTRL_START_BIT] && !fetch_busy) begin
                            start       = 1'b1;
                            regs_d.done = 1'b0;
                        end
                    end
                    REG_ADDR_LO: if (!fetch_busy) regs_d.lo  = wr_data;
                    REG_ADDR_HI: if (!fetch_busy) regs_d.hi  = wr_data[HI_W-1:0];
                    default:     if (!fetch_busy) regs_d.cfg = wr_data[CFG_W-1:0];
                endcase
            end
        end
        if (fetch_done) regs_d.done = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rd_data = '0;
        if (sel_port == PORT_IDX) begin
            rd_data[1:0] = regs_q.idx;
        end else begin
            case (regs_q.idx)
                REG_CTRL: begin
                    rd_data[CTRL_START_BIT] = fetch_busy;
                    rd_data[CTRL_IEN_BIT]   = regs_q.ien;
                    rd_data[CTRL_DONE_BIT]  = regs_q.done;
                end
                REG_ADDR_LO: rd_data = regs_q.lo;
                REG_ADDR_HI: rd_data[HI_W-1:0] = regs_q.hi;
                default:     rd_data[CFG_W-1:0] = regs_q.cfg;
            endcase
        end
    end

    assign base_addr = {regs_q.hi, regs_q.lo};
    assign cfg_swap  = regs_q.cfg[CFG_SWAP_BIT];
    assign done_flag = regs_q.done;
    assign irq       = regs_q.done & regs_q.ien;

    p_lo_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_busy && wr_en && sel_port == PORT_DATA && regs_q.idx == REG_ADDR_LO)
        |=> $stable(regs_q.lo));

    p_hi_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_busy && wr_en && sel_port == PORT_DATA && regs_q.idx == REG_ADDR_HI)
        |=> $stable(regs_q.hi));
endmodule

// File: rtl/icp_init_fetch.sv
module icp_init_fetch #(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned MEM_AW    = 24,
    parameter int unsigned IMG_WORDS = 12,
    parameter int unsigned IDX_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MEM_AW-1:0] base_addr,
    input  logic              swap,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic [MEM_AW-1:0] mem_addr,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [IDX_W-1:0]  img_idx,
    output logic [DATA_W-1:0] img_word
);
    localparam int unsigned CNT_W  = $clog2(IMG_WORDS);
    localparam int unsigned HALF_W = DATA_W / 2;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(IMG_WORDS - 1);

    typedef struct packed {
        logic                              busy;
        logic                              done;
        logic                              swap;
        logic [CNT_W-1:0]                  cnt;
        logic [MEM_AW-1:0]                 addr;
        logic [IMG_WORDS-1:0][DATA_W-1:0]  img;
    } fetch_t;

    fetch_t st_d, st_q;
    logic [DATA_W-1:0] beat_word;

    always_comb begin
        if (st_q.swap) beat_word = {mem_rdata[HALF_W-1:0], mem_rdata[DATA_W-1:HALF_W]};
        else           beat_word = mem_rdata;
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.cnt  = '0;
                st_d.addr = base_addr;
                st_d.swap = swap;
            end
        end else if (mem_gnt) begin
            st_d.img[st_q.cnt] = beat_word;
            st_d.addr          = st_q.addr + 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy     = st_q.busy;
    assign done     = st_q.done;
    assign mem_req  = st_q.busy;
    assign mem_addr = st_q.addr;

    always_comb begin
        img_word = '0;
        if (32'(img_idx) < IMG_WORDS) img_word = st_q.img[img_idx[CNT_W-1:0]];
    end

    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (32'(st_q.cnt) < IMG_WORDS));

    p_addr_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt && !done && st_q.cnt != LAST) |=> (mem_addr == $past(mem_addr) + 1'b1));
endmodule

// File: rtl/indirect_csr_port.sv
module indirect_csr_port #(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned MEM_AW    = 24,
    parameter int unsigned IMG_WORDS = 12,
    parameter int unsigned CFG_W     = 3,
    parameter int unsigned IDX_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_port,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              mem_req,
    output logic [MEM_AW-1:0] mem_addr,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [IDX_W-1:0]  img_idx,
    output logic [DATA_W-1:0] img_word,
    output logic              irq
);
    logic              start;
    logic              fetch_busy;
    logic              fetch_done;
    logic              cfg_swap;
    logic              done_flag;
    logic [MEM_AW-1:0] base_addr;

    icp_regfile #(
        .DATA_W (DATA_W),
        .MEM_AW (MEM_AW),
        .CFG_W  (CFG_W)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (host_wr),
        .sel_port   (host_port),
        .wr_data    (host_wdata),
        .rd_data    (host_rdata),
        .fetch_busy (fetch_busy),
        .fetch_done (fetch_done),
        .start      (start),
        .base_addr  (base_addr),
        .cfg_swap   (cfg_swap),
        .done_flag  (done_flag),
        .irq        (irq)
    );

    icp_init_fetch #(
        .DATA_W    (DATA_W),
        .MEM_AW    (MEM_AW),
        .IMG_WORDS (IMG_WORDS),
        .IDX_W     (IDX_W)
    ) fetch_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .base_addr (base_addr),
        .swap      (cfg_swap),
        .busy      (fetch_busy),
        .done      (fetch_done),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_gnt   (mem_gnt),
        .mem_rdata (mem_rdata),
        .img_idx   (img_idx),
        .img_word  (img_word)
    );

    p_start_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !fetch_busy);

    p_start_runs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (fetch_busy && mem_req));

    p_done_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_done |=> done_flag);

    p_irq_needs_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done_flag);
endmodule

// File: tb/indirect_csr_port_tb.sv
module indirect_csr_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_port = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        mem_req;
    logic [23:0] mem_addr;
    logic        mem_gnt = 1'b0;
    logic [15:0] mem_rdata;
    logic [3:0]  img_idx = '0;
    logic [15:0] img_word;
    logic        irq;

    int checks = 0;
    int failures = 0;
    int beats = 0;
    logic [23:0] exp_base = '0;
    logic        gnt_seen_req = 1'b0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    indirect_csr_port dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_port(host_port),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .img_idx(img_idx), .img_word(img_word), .irq(irq)
    );

    function automatic logic [15:0] mem_model(input logic [23:0] a);
        return a[15:0] ^ {a[23:16], 8'h5A};
    endfunction

    function automatic logic [15:0] exp_img(input logic [23:0] a, input logic sw);
        logic [15:0] w = mem_model(a);
        return sw ? {w[7:0], w[15:8]} : w;
    endfunction

    function automatic logic [15:0] reg_mask(input int idx);
        case (idx)
            1: return 16'hFFFF;
            2: return 16'h00FF;
            3: return 16'h0007;
            default: return 16'h0000;
        endcase
    endfunction

    assign mem_rdata = mem_model(mem_addr);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model: random grants, checks address sequence
    always @(negedge clk) begin
        if (mem_gnt && gnt_seen_req) beats++;
        if (mem_req) check("R6/R11 fetch address", mem_addr, (exp_base + 24'(beats)) & 24'hFFFFFF);
        gnt_seen_req <= mem_req;
        mem_gnt <= mem_req && ($urandom % 3 != 0);
    end

    task automatic wr(input logic port, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_port = port; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic port, output logic [15:0] d);
        host_port = port;
        #1;
        d = host_rdata;
    endtask

    task automatic rd_reg(input int idx, output logic [15:0] d);
        wr(1'b1, 16'(idx));
        rd(1'b0, d);
    endtask

    task automatic wr_reg(input int idx, input logic [15:0] v);
        wr(1'b1, 16'(idx));
        wr(1'b0, v);
    endtask

    task automatic run_fetch(input logic [15:0] lo, input logic [7:0] hi, input logic sw, input logic ien);
        logic [15:0] r;
        wr_reg(1, lo);
        wr_reg(2, {8'hA5, hi});
        wr_reg(3, {13'h0, 2'b10, sw});
        exp_base = {hi, lo};
        beats = 0;
        wr_reg(0, ien ? 16'h0041 : 16'h0001);
        rd(1'b0, r);
        check("R5 start bit reads 1 while running", r[0], 1'b1);
        check("R5 done cleared by start", r[8], 1'b0);
        // write attempts while busy must be ignored
        wr_reg(1, ~lo);
        wr_reg(3, {13'h0, 3'b001 ^ {2'b10, sw}});
        rd_reg(1, r);
        check("R10 reg1 write ignored while busy", r, lo);
        rd_reg(3, r);
        check("R10 reg3 write ignored while busy", r, {13'h0, 2'b10, sw});
        wr(1'b1, 16'd0);
        for (int k = 0; k < 400; k++) begin
            rd(1'b0, r);
            if (r[8]) break;
            @(negedge clk);
        end
        @(negedge clk);
        rd(1'b0, r);
        check("R8 done set", r[8], 1'b1);
        check("R5 start bit cleared after fetch", r[0], 1'b0);
        check("R6 twelve beats", beats, 12);
        check("R6 request dropped", mem_req, 1'b0);
        check("R9 irq when done and enabled", irq, ien);
        for (int i = 0; i < 12; i++) begin
            img_idx = 4'(i);
            #1;
            check("R7 image word", img_word, exp_img(exp_base + 24'(i), sw));
        end
        img_idx = 4'd13;
        #1;
        check("R7 index beyond image", img_word, 16'h0);
        wr(1'b0, ien ? 16'h0040 : 16'h0000);
        rd(1'b0, r);
        check("R8 write 0 keeps done", r[8], 1'b1);
        wr(1'b0, 16'h0100);
        rd(1'b0, r);
        check("R8 write 1 clears done", r[8], 1'b0);
        check("R9 irq low after clear", irq, 1'b0);
    endtask

    initial begin
        logic [15:0] r;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        #1;
        check("R1 mem_req at reset", mem_req, 1'b0);
        check("R1 irq at reset", irq, 1'b0);
        rd(1'b1, r);
        check("R1 index at reset", r, 16'h0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            wr(1'b1, 16'(i));
            rd(1'b0, r);
            check("R1 register reset value", r, 16'h0);
        end
        // index port random patterns
        for (int i = 0; i < 10; i++) begin
            logic [15:0] v = 16'($urandom);
            wr(1'b1, v);
            rd(1'b1, r);
            check("R2 index readback", r, {14'h0, v[1:0]});
        end
        // random data-port writes to regs 1..3
        for (int i = 0; i < 20; i++) begin
            int idx = 1 + int'($urandom % 3);
            logic [15:0] v = 16'($urandom);
            wr_reg(idx, v);
            rd_reg(idx, r);
            check(idx == 1 ? "R3 reg1 readback" : "R4 masked readback", r, v & reg_mask(idx));
        end
        // control register enable bit readback
        wr_reg(0, 16'h0040);
        rd(1'b0, r);
        check("R3 control ien readback", r, 16'h0040);
        wr(1'b0, 16'h0000);
        run_fetch(16'h1230, 8'h45, 1'b0, 1'b1);
        run_fetch(16'hBEEF, 8'h07, 1'b1, 1'b0);
        run_fetch(16'hFFF8, 8'hFF, 1'b0, 1'b1);   // R11 wrap past top of space
        run_fetch(16'($urandom), 8'($urandom), 1'b1, 1'b1);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule